// File: doc/BRIEF.md
# Prefix-Aware Undefined Opcode Trap Unit

This unit sits beside the fetch path of an 8-bit processor core whose instruction set extends its opcode space with prefix bytes. It follows each opcode byte the core fetches and keeps track of whether a single prefix or a two-byte prefix pair is pending. When the byte that completes a prefixed opcode is not a defined instruction, the unit takes over the bus. It raises a sticky trap flag and notes whether the bad byte was the second or the third of the instruction. It then stalls the core through a fixed number of internal cycles and writes the address of the bad byte onto a downward-growing stack, high byte first. Finally it hands the core a new fetch address of zero.

Software running at the restart vector reads the control/status byte. The trap flag tells a trap apart from a cold start. The position flag tells it whether to subtract one or two from the stacked address to find where the faulting instruction began. The handler clears the flag by writing zero to it. The sets of undefined bytes are parameters, one 256-bit mask per prefix class, so the unit can be fitted to a given instruction set.

Top module: `undef_trap_unit`

## Requirements
- R1: After reset the status byte reads 00h, `busy_o` is low, and no stack write, stack-pointer load or redirect is issued.
- R2: A byte marked undefined in its class mask that directly follows a single prefix raises a trap. The single prefixes are CBh, EDh, DDh and FDh. A DDh or FDh followed by CBh is instead a prefix pair. The trap reads back with bit 7 = 1 and bit 6 = 0.
- R3: A byte marked undefined in the pair mask that directly follows the pair DDh CBh or FDh CBh raises a trap that reads back with bit 7 = 1 and bit 6 = 1.
- R4: Bytes not marked undefined never start a trap. With the default masks these include CB 00, ED 40, DD 21, FD 09, DD CB 06 and an unprefixed 30.
- R5: The trap is detected on the clock edge that accepts the fetch. Then one trap cycle passes, followed by `IDLE_CYCLES` idle cycles (default 3). The high-byte write comes on edge `IDLE_CYCLES`+1 after the accepting edge, and the low-byte write on the edge after that.
- R6: The high write puts fetch-address bits 15:8 of the undefined byte at SP-1. The low write puts bits 7:0 at SP-2. SP is the value of `sp_i` at detection, and the addresses wrap modulo 2^16.
- R7: `sp_load_o` pulses together with the low-byte write, with `sp_next_o` = SP-2.
- R8: In the cycle after the low-byte write, `redirect_o` pulses for one cycle with `redirect_addr_o` = 0000h. After that `busy_o` falls.
- R9: Bit 7 stays set until a status write with `csr_wtrap_i` = 0. A write with `csr_wtrap_i` = 1 leaves it unchanged.
- R10: Status writes never change bit 6. Bit 6 takes a new value only when a trap starts.
- R11: Fetches presented while `busy_o` is high are ignored. A trap discards any pending prefix, so the next byte is decoded as unprefixed.
- R12: Any non-prefix byte that completes an instruction returns prefix tracking to the unprefixed state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_n_i | input | 1 | Asynchronous active-low reset |
| fetch_vld_i | input | 1 | Opcode byte fetched this cycle |
| fetch_byte_i | input | 8 | Fetched opcode byte |
| fetch_pc_i | input | 16 | Address of the fetched byte |
| sp_i | input | 16 | Current stack pointer of the core |
| busy_o | output | 1 | Trap sequence active, core must stall |
| mem_wr_o | output | 1 | Stack byte write strobe |
| mem_addr_o | output | 16 | Stack write address |
| mem_wdata_o | output | 8 | Stack write data |
| sp_load_o | output | 1 | Load new stack pointer |
| sp_next_o | output | 16 | New stack pointer value |
| redirect_o | output | 1 | Restart fetching at the vector |
| redirect_addr_o | output | 16 | Restart address |
| csr_wr_i | input | 1 | Status/control write strobe |
| csr_wtrap_i | input | 1 | Value written to the trap flag |
| csr_rdata_o | output | 8 | Status byte: bit 7 trap, bit 6 third-byte flag |

## Verification
The hardest case to reach from the ports is a prefix state that is left over while the sequencer owns the bus. Stimulus that looks like a trap is offered during `busy_o`, and a lone byte follows that would be undefined only if a prefix were still pending. The bench therefore sends fetch strobes, including a prefix and an undefined byte, in the middle of a running sequence. Its scoreboard expects no second sequence and no trap from the lone byte afterwards. A stack pointer of 0001h drives the write addresses through the 16-bit wrap.

// File: rtl/trap_pkg.sv
package trap_pkg;
  localparam int unsigned ADDR_W = 16;
  localparam int unsigned BYTE_W = 8;

  localparam logic [BYTE_W-1:0] OP_BIT  = 8'hCB;
  localparam logic [BYTE_W-1:0] OP_EXT  = 8'hED;
  localparam logic [BYTE_W-1:0] OP_IDXA = 8'hDD;
  localparam logic [BYTE_W-1:0] OP_IDXB = 8'hFD;

  localparam int unsigned CSR_TRAP_BIT = 7;
  localparam int unsigned CSR_POS_BIT  = 6;

  typedef enum logic [2:0] {
    PFX_NONE,
    PFX_BIT,
    PFX_EXT,
    PFX_IDX,
    PFX_IDXBIT
  } pfx_state_t;

  typedef enum logic [2:0] {
    SEQ_IDLE,
    SEQ_TRAP,
    SEQ_WAIT,
    SEQ_PUSH_HI,
    SEQ_PUSH_LO,
    SEQ_VECTOR
  } seq_state_t;
endpackage

// File: rtl/trap_prefix_tracker.sv
module trap_prefix_tracker
  import trap_pkg::*;
#(
  parameter logic [255:0] UNDEF_BIT    = 256'h00FF000000000000,
  parameter logic [255:0] UNDEF_EXT    = {64'hFFFFFFFFFFFFFFFF, 192'h0},
  parameter logic [255:0] UNDEF_IDX    = 256'h1FF,
  parameter logic [255:0] UNDEF_IDXBIT = 256'h3F
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              accept,
  input  logic [BYTE_W-1:0] op_byte,
  output logic              hit,
  output logic              hit_third
);
  pfx_state_t st_q, st_d;

  always_comb begin
    st_d      = st_q;
    hit       = 1'b0;
    hit_third = 1'b0;
    if (accept) begin
      unique case (st_q)
        PFX_NONE: begin
          if (op_byte == OP_BIT)                          st_d = PFX_BIT;
          else if (op_byte == OP_EXT)                     st_d = PFX_EXT;
          else if (op_byte == OP_IDXA || op_byte == OP_IDXB) st_d = PFX_IDX;
          else                                            st_d = PFX_NONE;
        end
        PFX_BIT: begin
          hit  = UNDEF_BIT[op_byte];
          st_d = PFX_NONE;
        end
        PFX_EXT: begin
          hit  = UNDEF_EXT[op_byte];
          st_d = PFX_NONE;
        end
        PFX_IDX: begin
          if (op_byte == OP_BIT) begin
            st_d = PFX_IDXBIT;
          end else begin
            hit  = UNDEF_IDX[op_byte];
            st_d = PFX_NONE;
          end
        end
        PFX_IDXBIT: begin
          hit       = UNDEF_IDXBIT[op_byte];
          hit_third = UNDEF_IDXBIT[op_byte];
          st_d      = PFX_NONE;
        end
        default: st_d = PFX_NONE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= PFX_NONE;
    else        st_q <= st_d;
  end
endmodule

// File: rtl/trap_stack_seq.sv
module trap_stack_seq
  import trap_pkg::*;
#(
  parameter int unsigned      IDLE_CYCLES = 3,
  parameter logic [ADDR_W-1:0] VECTOR     = '0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [ADDR_W-1:0] pc_in,
  input  logic [ADDR_W-1:0] sp_in,
  output logic              busy,
  output logic              mem_wr,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [BYTE_W-1:0] mem_wdata,
  output logic              sp_load,
  output logic [ADDR_W-1:0] sp_next,
  output logic              redirect,
  output logic [ADDR_W-1:0] redirect_addr
);
  localparam int unsigned CNT_W = (IDLE_CYCLES < 2) ? 1 : $clog2(IDLE_CYCLES);
  localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(IDLE_CYCLES - 1);

  seq_state_t        st_q, st_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic              cnt_en;
  logic [ADDR_W-1:0] pc_q, sp_q;
  logic              cap_en;
  logic [ADDR_W-1:0] sp_m1, sp_m2;

  assign cap_en = start && (st_q == SEQ_IDLE);
  assign sp_m1  = sp_q - ADDR_W'(1);
  assign sp_m2  = sp_q - ADDR_W'(2);

  always_comb begin
    st_d   = st_q;
    cnt_d  = cnt_q;
    cnt_en = 1'b0;
    unique case (st_q)
      SEQ_IDLE:    if (start) st_d = SEQ_TRAP;
      SEQ_TRAP: begin
        st_d   = SEQ_WAIT;
        cnt_d  = CNT_LOAD;
        cnt_en = 1'b1;
      end
      SEQ_WAIT: begin
        if (cnt_q == '0) begin
          st_d = SEQ_PUSH_HI;
        end else begin
          cnt_d  = cnt_q - CNT_W'(1);
          cnt_en = 1'b1;
        end
      end
      SEQ_PUSH_HI: st_d = SEQ_PUSH_LO;
      SEQ_PUSH_LO: st_d = SEQ_VECTOR;
      SEQ_VECTOR:  st_d = SEQ_IDLE;
      default:     st_d = SEQ_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= SEQ_IDLE;
      cnt_q <= '0;
      pc_q  <= '0;
      sp_q  <= '0;
    end else begin
      st_q <= st_d;
      if (cnt_en) cnt_q <= cnt_d;
      if (cap_en) begin
        pc_q <= pc_in;
        sp_q <= sp_in;
      end
    end
  end

  assign busy          = (st_q != SEQ_IDLE);
  assign mem_wr        = (st_q == SEQ_PUSH_HI) || (st_q == SEQ_PUSH_LO);
  assign mem_addr      = (st_q == SEQ_PUSH_HI) ? sp_m1 : sp_m2;
  assign mem_wdata     = (st_q == SEQ_PUSH_HI) ? pc_q[ADDR_W-1 -: BYTE_W] : pc_q[BYTE_W-1:0];
  assign sp_load       = (st_q == SEQ_PUSH_LO);
  assign sp_next       = sp_m2;
  assign redirect      = (st_q == SEQ_VECTOR);
  assign redirect_addr = VECTOR;
endmodule

// File: rtl/trap_status_reg.sv
module trap_status_reg
  import trap_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              trap_set,
  input  logic              third_byte,
  input  logic              wr,
  input  logic              wtrap,
  output logic [BYTE_W-1:0] rdata
);
  logic trap_q, trap_d, pos_q;

  always_comb begin
    trap_d = trap_q;
    if (wr && !wtrap) trap_d = 1'b0;
    if (trap_set)     trap_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      trap_q <= 1'b0;
      pos_q  <= 1'b0;
    end else begin
      trap_q <= trap_d;
      if (trap_set) pos_q <= third_byte;
    end
  end

  always_comb begin
    rdata               = '0;
    rdata[CSR_TRAP_BIT] = trap_q;
    rdata[CSR_POS_BIT]  = pos_q;
  end
endmodule

// File: rtl/undef_trap_unit.sv
module undef_trap_unit
  import trap_pkg::*;
#(
  parameter int unsigned  IDLE_CYCLES  = 3,
  parameter logic [255:0] UNDEF_BIT    = 256'h00FF000000000000,
  parameter logic [255:0] UNDEF_EXT    = {64'hFFFFFFFFFFFFFFFF, 192'h0},
  parameter logic [255:0] UNDEF_IDX    = 256'h1FF,
  parameter logic [255:0] UNDEF_IDXBIT = 256'h3F
) (
  input  logic              clk_i,
  input  logic              rst_n_i,
  input  logic              fetch_vld_i,
  input  logic [BYTE_W-1:0] fetch_byte_i,
  input  logic [ADDR_W-1:0] fetch_pc_i,
  input  logic [ADDR_W-1:0] sp_i,
  output logic              busy_o,
  output logic              mem_wr_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic [BYTE_W-1:0] mem_wdata_o,
  output logic              sp_load_o,
  output logic [ADDR_W-1:0] sp_next_o,
  output logic              redirect_o,
  output logic [ADDR_W-1:0] redirect_addr_o,
  input  logic              csr_wr_i,
  input  logic              csr_wtrap_i,
  output logic [BYTE_W-1:0] csr_rdata_o
);
  logic rst_meta_q, rst_sync_q;
  logic accept, hit, hit_third, busy;

  always_ff @(posedge clk_i or negedge rst_n_i) begin
    if (!rst_n_i) begin
      rst_meta_q <= 1'b0;
      rst_sync_q <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_q <= rst_meta_q;
    end
  end

  assign accept = fetch_vld_i && !busy;

  trap_prefix_tracker #(
    .UNDEF_BIT   (UNDEF_BIT),
    .UNDEF_EXT   (UNDEF_EXT),
    .UNDEF_IDX   (UNDEF_IDX),
    .UNDEF_IDXBIT(UNDEF_IDXBIT)
  ) u_pfx (
    .clk      (clk_i),
    .rst_n    (rst_sync_q),
    .accept   (accept),
    .op_byte  (fetch_byte_i),
    .hit      (hit),
    .hit_third(hit_third)
  );

  trap_stack_seq #(
    .IDLE_CYCLES(IDLE_CYCLES),
    .VECTOR     ('0)
  ) u_seq (
    .clk          (clk_i),
    .rst_n        (rst_sync_q),
    .start        (hit),
    .pc_in        (fetch_pc_i),
    .sp_in        (sp_i),
    .busy         (busy),
    .mem_wr       (mem_wr_o),
    .mem_addr     (mem_addr_o),
    .mem_wdata    (mem_wdata_o),
    .sp_load      (sp_load_o),
    .sp_next      (sp_next_o),
    .redirect     (redirect_o),
    .redirect_addr(redirect_addr_o)
  );

  trap_status_reg u_csr (
    .clk       (clk_i),
    .rst_n     (rst_sync_q),
    .trap_set  (hit),
    .third_byte(hit_third),
    .wr        (csr_wr_i),
    .wtrap     (csr_wtrap_i),
    .rdata     (csr_rdata_o)
  );

  assign busy_o = busy;
endmodule

// File: rtl/trap_unit_chk.sv
module trap_unit_chk
  import trap_pkg::*;
(
  input logic              clk_i,
  input logic              rst_n_i,
  input logic              busy_o,
  input logic              mem_wr_o,
  input logic [ADDR_W-1:0] mem_addr_o,
  input logic              sp_load_o,
  input logic [ADDR_W-1:0] sp_next_o,
  input logic              redirect_o,
  input logic [ADDR_W-1:0] redirect_addr_o,
  input logic              csr_wr_i,
  input logic [BYTE_W-1:0] csr_rdata_o
);
  // R1: bus activity only inside a busy window
  a_r1_quiet_when_idle: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    !busy_o |-> (!mem_wr_o && !sp_load_o && !redirect_o));

  // R5: high-byte write is followed directly by the low-byte write
  a_r5_hi_then_lo: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    (mem_wr_o && !sp_load_o) |=> (mem_wr_o && sp_load_o));

  // R6: consecutive stack writes step the address down by one
  a_r6_addr_step: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    (mem_wr_o && !sp_load_o) |=> (mem_addr_o == $past(mem_addr_o) - ADDR_W'(1)));

  // R7: new stack pointer equals the low-byte address
  a_r7_sp_matches_lo: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    sp_load_o |-> (mem_wr_o && sp_next_o == mem_addr_o));

  // R8: redirect to address zero right after the low write
  a_r8_vector_after_lo: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    sp_load_o |=> (redirect_o && redirect_addr_o == '0 && !mem_wr_o));

  a_r8_release_after_vector: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    redirect_o |=> !busy_o);

  // R9: trap flag holds without a write
  a_r9_trap_sticky: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    (csr_rdata_o[CSR_TRAP_BIT] && !csr_wr_i) |=> csr_rdata_o[CSR_TRAP_BIT]);

  // R10: position flag changes only when a trap starts
  a_r10_pos_only_on_trap: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    !$rose(busy_o) |-> $stable(csr_rdata_o[CSR_POS_BIT]));
endmodule

bind undef_trap_unit trap_unit_chk u_chk (
  .clk_i          (clk_i),
  .rst_n_i        (rst_n_i),
  .busy_o         (busy_o),
  .mem_wr_o       (mem_wr_o),
  .mem_addr_o     (mem_addr_o),
  .sp_load_o      (sp_load_o),
  .sp_next_o      (sp_next_o),
  .redirect_o     (redirect_o),
  .redirect_addr_o(redirect_addr_o),
  .csr_wr_i       (csr_wr_i),
  .csr_rdata_o    (csr_rdata_o)
);

// File: tb/tb_undef_trap_unit.sv
module tb_undef_trap_unit;
  localparam int IDLE = 3;

  typedef struct {
    int          cyc;
    logic        wr;
    logic        spl;
    logic        rdr;
    logic [15:0] addr;
    logic [7:0]  data;
    logic [15:0] sp;
    string       req;
  } ev_t;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        fvld = 1'b0;
  logic [7:0]  fbyte = '0;
  logic [15:0] fpc = '0;
  logic [15:0] sp = 16'h8000;
  logic        cwr = 1'b0;
  logic        cwt = 1'b0;
  logic        busy, mwr, spl, rdr;
  logic [15:0] maddr, spn, raddr;
  logic [7:0]  mdata, csr;

  int cyc = 0;
  int tests = 0;
  int fails = 0;
  ev_t expq[$];

  undef_trap_unit #(.IDLE_CYCLES(IDLE)) dut (
    .clk_i(clk), .rst_n_i(rst_n),
    .fetch_vld_i(fvld), .fetch_byte_i(fbyte), .fetch_pc_i(fpc), .sp_i(sp),
    .busy_o(busy), .mem_wr_o(mwr), .mem_addr_o(maddr), .mem_wdata_o(mdata),
    .sp_load_o(spl), .sp_next_o(spn), .redirect_o(rdr), .redirect_addr_o(raddr),
    .csr_wr_i(cwr), .csr_wtrap_i(cwt), .csr_rdata_o(csr)
  );

  always #2 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(string req, logic [31:0] act, logic [31:0] exp, string what);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // monitor: pop expected bus events and compare
  always @(negedge clk) begin
    if (rst_n && (mwr || spl || rdr)) begin
      if (expq.size() == 0) begin
        tests++; fails++;
        $display("FAIL R4 unexpected bus activity: actual wr=%b spl=%b rdr=%b expected none at cycle %0d",
                 mwr, spl, rdr, cyc);
      end else begin
        ev_t e;
        e = expq.pop_front();
        check(e.req, cyc, e.cyc, "event cycle");
        check(e.req, {mwr, spl, rdr}, {e.wr, e.spl, e.rdr}, "strobes");
        check(e.req, rdr ? raddr : maddr, e.addr, "address");
        if (e.wr)  check(e.req, mdata, e.data, "write data");
        if (e.spl) check("R7", spn, e.sp, "new stack pointer");
      end
    end
  end

  task automatic fetch(input logic [7:0] b, input logic [15:0] pc, output int cap);
    @(negedge clk);
    fvld = 1'b1; fbyte = b; fpc = pc;
    cap = cyc + 1;
    @(negedge clk);
    fvld = 1'b0;
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic expect_trap(int cap, logic [15:0] pc, logic [15:0] s, string req);
    ev_t e;
    e = '{cap + IDLE + 1, 1'b1, 1'b0, 1'b0, s - 16'd1, pc[15:8], 16'h0, "R6"};
    expq.push_back(e);
    e = '{cap + IDLE + 2, 1'b1, 1'b1, 1'b0, s - 16'd2, pc[7:0], s - 16'd2, "R6"};
    expq.push_back(e);
    e = '{cap + IDLE + 3, 1'b0, 1'b0, 1'b1, 16'h0000, 8'h00, 16'h0, "R8"};
    expq.push_back(e);
    if (req != "") ;
  endtask

  task automatic csr_write(logic v);
    @(negedge clk);
    cwr = 1'b1; cwt = v;
    @(negedge clk);
    cwr = 1'b0;
  endtask

  // two-byte trap: prefix then undefined byte
  task automatic trap2(logic [7:0] p, logic [7:0] b, logic [15:0] pc, logic [15:0] s, string req);
    int c;
    sp = s;
    fetch(p, pc, c);
    fetch(b, pc + 16'd1, c);
    expect_trap(c, pc + 16'd1, s, req);
    idle(IDLE + 6);
  endtask

  initial begin
    int c;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    idle(4);
    // R1
    check("R1", csr, 8'h00, "status after reset");
    check("R1", busy, 1'b0, "busy after reset");

    // R4 / R12: defined sequences never trap
    fetch(8'hCB, 16'h0100, c); fetch(8'h00, 16'h0101, c);
    fetch(8'hED, 16'h0102, c); fetch(8'h40, 16'h0103, c);
    fetch(8'hDD, 16'h0104, c); fetch(8'h21, 16'h0105, c);
    fetch(8'hFD, 16'h0106, c); fetch(8'h09, 16'h0107, c);
    fetch(8'hDD, 16'h0108, c); fetch(8'hCB, 16'h0109, c); fetch(8'h06, 16'h010A, c);
    fetch(8'h30, 16'h010B, c); // R12: tracking back to unprefixed, 30 alone is defined
    idle(12);
    check("R4", csr, 8'h00, "status after defined bytes");
    check("R4", busy, 1'b0, "busy after defined bytes");

    // R2: CB-prefixed undefined
    trap2(8'hCB, 8'h30, 16'h1000, 16'h8000, "R2");
    check("R2", csr, 8'h80, "status after CB trap");
    check("R9", busy, 1'b0, "busy released");
    csr_write(1'b1);
    check("R9", csr, 8'h80, "write 1 keeps trap flag");
    idle(3);
    check("R9", csr, 8'h80, "trap flag sticky");
    csr_write(1'b0);
    check("R9", csr, 8'h00, "write 0 clears trap flag");

    // R3: DD CB xx undefined third byte
    sp = 16'h4000;
    fetch(8'hDD, 16'h2000, c); fetch(8'hCB, 16'h2001, c); fetch(8'h02, 16'h2002, c);
    expect_trap(c, 16'h2002, 16'h4000, "R3");
    idle(IDLE + 6);
    check("R3", csr, 8'hC0, "status after DDCB trap");
    csr_write(1'b0);
    check("R10", csr, 8'h40, "position flag survives write");
    csr_write(1'b1);
    check("R10", csr, 8'h40, "position flag unchanged by write 1");

    // R6 wrap: ED prefix with SP=0001
    trap2(8'hED, 8'hC5, 16'hABCD, 16'h0001, "R6");
    check("R10", csr, 8'h80, "position flag updated by next trap");
    csr_write(1'b0);

    // R2 with FD/DD, R3 with FD CB
    trap2(8'hFD, 8'h08, 16'h3455, 16'hC000, "R2");
    check("R2", csr, 8'h80, "status after FD trap");
    sp = 16'hC100;
    fetch(8'hFD, 16'h5FFE, c); fetch(8'hCB, 16'h5FFF, c); fetch(8'h05, 16'h6000, c);
    expect_trap(c, 16'h6000, 16'hC100, "R3");
    idle(IDLE + 6);
    check("R3", csr, 8'hC0, "status after FDCB trap");
    trap2(8'hDD, 8'h03, 16'h7777, 16'h9000, "R2");
    check("R2", csr, 8'h80, "status after DD trap");
    csr_write(1'b0);

    // R11: fetches while busy ignored, pending prefix discarded
    sp = 16'h5000;
    fetch(8'hCB, 16'h4000, c); fetch(8'h30, 16'h4001, c);
    expect_trap(c, 16'h4001, 16'h5000, "R11");
    fetch(8'hCB, 16'h4100, c); fetch(8'h30, 16'h4101, c); fetch(8'hED, 16'h4102, c);
    idle(IDLE + 4);
    check("R11", busy, 1'b0, "sequence finished");
    fetch(8'h30, 16'h0000, c);
    fetch(8'hC5, 16'h0001, c);
    idle(10);
    check("R11", busy, 1'b0, "no trap from stale prefix");
    check("R11", csr, 8'h80, "status unchanged by ignored fetches");

    check("R5", expq.size(), 0, "all expected events seen");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    #200000;
    tests++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule